// File: doc/BRIEF.md
# Translation Lookaside Buffer with Locked and Rotating Entries

This block is a fully associative translation buffer holding 32 entries for 32-bit virtual addresses. Each cycle it accepts one lookup carrying a virtual address, an address-space tag and a store flag. One cycle later it returns a registered result. The result holds the physical address, a cache-attribute field, a success flag and an exception code. The exception code tells software whether the page is missing, present but invalid, or present but write-protected for a store.

Every entry carries its own page-size mask. Small and large pages can therefore sit side by side. The low virtual-page bits that a mask covers are left out of the compare, and they pass unchanged into the physical address. A programmable locked count protects the lowest entries. A rotating replacement index steps downward through the remaining entries only. Software fills the buffer in one of two ways: an indexed write to a named slot, or a replacement write to whatever slot the rotating index points at in that cycle.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup presented with `lk_valid` high at a clock edge yields `res_valid` high with its result after that same edge, so the result is seen one cycle later. A hit and a miss take the same number of cycles. With `lk_valid` low, `res_valid` is low one cycle later.
- R2: An entry matches when two conditions hold. First, its virtual page number equals the request's page number (`lk_vaddr[31:12]`) on every bit its mask does not cover; mask bit i covers page-number bit i, for i below 8. Second, either the address-space tags are equal or the entry's global bit is set. When several entries match, the one with the lowest index is used.
- R3: On a successful lookup, `res_paddr` is built from three parts. Page-number bits covered by the entry's mask come from the virtual address. The other page-number bits come from the entry's frame number. The 12-bit page offset passes through unchanged. `res_cattr` returns the entry's attribute field.
- R4: When no entry matches, `res_exc` is 1 (refill).
- R5: When the selected entry has its valid bit clear, `res_exc` is 2 (invalid).
- R6: A store that selects a valid entry with a clear dirty bit gives `res_exc` 3 (modified). A load to the same entry succeeds with `res_exc` 0.
- R7: Whenever `res_exc` is not 0, `res_hit` is 0 and both `res_paddr` and `res_cattr` are 0. When `res_exc` is 0, `res_hit` is 1.
- R8: An indexed write (`wr_en` high, `wr_random` low) loads all fields into entry `wr_index` at the clock edge. Lookups presented after that edge see the new contents, including a replacement of an earlier mapping.
- R9: After reset, and after every write of the locked count, the rotating index `rand_idx` holds 31. It then falls by one every cycle. In the cycle after it equals the locked count, it returns to 31.
- R10: A write of the locked count (`wired_we`) takes effect at the clock edge. It restricts the rotating index to the range from that count up to 31.
- R11: A replacement write (`wr_en` and `wr_random` high) goes to the entry that `rand_idx` names in that cycle. It never changes an entry below the locked count; such entries keep translating as before.
- R12: Reset leaves several things in a known state. `res_valid` is 0, the locked count is 0 and `rand_idx` is 31. Every entry has all fields zero, so a load of virtual address 0 with tag 0 reports code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space tag of the request |
| lk_store | input | 1 | Request is a store |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Translation succeeded |
| res_exc | output | 2 | 0 none, 1 refill, 2 invalid, 3 modified |
| res_paddr | output | 32 | Physical address |
| res_cattr | output | 3 | Cache attribute of the page |
| wr_en | input | 1 | Entry write strobe |
| wr_random | input | 1 | 1: write at rotating index, 0: write at `wr_index` |
| wr_index | input | 5 | Target slot for indexed writes |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 8 | Address-space tag to store |
| wr_mask | input | 8 | Page-size mask to store |
| wr_global | input | 1 | Ignore the address-space tag |
| wr_pfn | input | 20 | Frame number to store |
| wr_valid | input | 1 | Entry valid bit |
| wr_dirty | input | 1 | Entry writable bit |
| wr_cattr | input | 3 | Cache attribute to store |
| wired_we | input | 1 | Write the locked count |
| wired_val | input | 5 | New locked count |
| rand_idx | output | 5 | Current rotating replacement index |

## Verification
The bench goes after five corner cases, each tied to a specific wrong design:

- **Duplicate matches.** Two entries map the same page. A design that picked the highest match would return the wrong frame and attribute.
- **Masked pages.** A large page uses a mask. A design that compared the masked bits, or took them from the frame number, would miss the page or build a wrong physical address.
- **Rotating index.** The index is followed through a complete walk from 31 down to 0 and around again, then through a short cycle after the locked count is raised. An off-by-one wrap, or failing to reload on a locked-count write, shows up in the exact sequence.
- **Replacement writes.** A burst of replacement writes runs after some entries are locked. Each mapping is then looked up, and so are the locked entries. A design that wrote below the locked count would clobber those older translations.
- **Exception split.** The global bit, a store to a clean page and an invalid entry each separate the three exception codes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    EXC_NONE     = 2'd0,
    EXC_REFILL   = 2'd1,
    EXC_INVALID  = 2'd2,
    EXC_MODIFIED = 2'd3
  } tlb_exc_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int MASK_W = 8
) (
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [MASK_W-1:0] e_mask,
  input  logic              e_global,
  output logic              hit
);
  localparam int PAD_W = VPN_W - MASK_W;

  logic [VPN_W-1:0] care;
  logic             vpn_eq;
  logic             asid_ok;

  // Bits covered by the mask are left out of the compare (R2)
  assign care    = ~{{PAD_W{1'b0}}, e_mask};
  assign vpn_eq  = ((q_vpn ^ e_vpn) & care) == '0;
  assign asid_ok = e_global || (q_asid == e_asid);
  assign hit     = vpn_eq && asid_ok;
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] below;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign below = (N'(1) << idx) - N'(1);

  // R2: the chosen slot requests, and no lower slot does
  always_comb begin
    if (found) begin
      a_r2_sel_requests: assert (req[idx]);
      a_r2_lowest_wins: assert ((req & below) == '0);
    end
  end
endmodule

// File: rtl/tlb_random.sv
module tlb_random #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wired_we,
  input  logic [IDX_W-1:0] wired_val,
  output logic [IDX_W-1:0] rand_idx,
  output logic [IDX_W-1:0] wired_cnt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rnd_q;
  logic [IDX_W-1:0] wired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wired_q <= '0;
      rnd_q   <= LAST;
    end else if (wired_we) begin
      wired_q <= wired_val;
      rnd_q   <= LAST;
    end else if (rnd_q <= wired_q) begin
      rnd_q <= LAST;
    end else begin
      rnd_q <= rnd_q - IDX_W'(1);
    end
  end

  assign rand_idx  = rnd_q;
  assign wired_cnt = wired_q;

  a_r10_in_range: assert property (@(posedge clk) disable iff (rst)
    rnd_q >= wired_q);
  a_r9_step_down: assert property (@(posedge clk) disable iff (rst)
    (!wired_we && rnd_q > wired_q) |=> rnd_q == $past(rnd_q) - IDX_W'(1));
  a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
    (!wired_we && rnd_q == wired_q) |=> rnd_q == LAST);
  a_r10_reload: assert property (@(posedge clk) disable iff (rst)
    wired_we |=> (rnd_q == LAST && wired_q == $past(wired_val)));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 8,
  parameter int CATTR_W = 3,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int VPN_W   = VA_W - PAGE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic               lk_store,
  output logic               res_valid,
  output logic               res_hit,
  output logic [1:0]         res_exc,
  output logic [VA_W-1:0]    res_paddr,
  output logic [CATTR_W-1:0] res_cattr,
  input  logic               wr_en,
  input  logic               wr_random,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [MASK_W-1:0]  wr_mask,
  input  logic               wr_global,
  input  logic [VPN_W-1:0]   wr_pfn,
  input  logic               wr_valid,
  input  logic               wr_dirty,
  input  logic [CATTR_W-1:0] wr_cattr,
  input  logic               wired_we,
  input  logic [IDX_W-1:0]   wired_val,
  output logic [IDX_W-1:0]   rand_idx
);
  import tlb_pkg::*;

  localparam int PAD_W = VPN_W - MASK_W;

  logic [VPN_W-1:0]   ent_vpn   [ENTRIES];
  logic [ASID_W-1:0]  ent_asid  [ENTRIES];
  logic [MASK_W-1:0]  ent_mask  [ENTRIES];
  logic               ent_glob  [ENTRIES];
  logic [VPN_W-1:0]   ent_pfn   [ENTRIES];
  logic               ent_valid [ENTRIES];
  logic               ent_dirty [ENTRIES];
  logic [CATTR_W-1:0] ent_cattr [ENTRIES];

  logic [ENTRIES-1:0] match_vec;
  logic [IDX_W-1:0]   wsel;
  logic [IDX_W-1:0]   wired_cnt;
  logic               any_match;
  logic [IDX_W-1:0]   sel;
  logic [VPN_W-1:0]   q_vpn;
  logic [VPN_W-1:0]   mext;
  logic [VPN_W-1:0]   frame;
  tlb_exc_e           exc_d;

  tlb_random #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rand (
    .clk(clk), .rst(rst), .wired_we(wired_we), .wired_val(wired_val),
    .rand_idx(rand_idx), .wired_cnt(wired_cnt)
  );

  // Replacement writes use the rotating index of this cycle (R11)
  assign wsel  = wr_random ? rand_idx : wr_index;
  assign q_vpn = lk_vaddr[VA_W-1:PAGE_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_vpn[g]   <= '0;
        ent_asid[g]  <= '0;
        ent_mask[g]  <= '0;
        ent_glob[g]  <= 1'b0;
        ent_pfn[g]   <= '0;
        ent_valid[g] <= 1'b0;
        ent_dirty[g] <= 1'b0;
        ent_cattr[g] <= '0;
      end else if (wr_en && wsel == IDX_W'(g)) begin
        ent_vpn[g]   <= wr_vpn;
        ent_asid[g]  <= wr_asid;
        ent_mask[g]  <= wr_mask;
        ent_glob[g]  <= wr_global;
        ent_pfn[g]   <= wr_pfn;
        ent_valid[g] <= wr_valid;
        ent_dirty[g] <= wr_dirty;
        ent_cattr[g] <= wr_cattr;
      end
    end

    tlb_match #(.VPN_W(VPN_W), .ASID_W(ASID_W), .MASK_W(MASK_W)) u_cmp (
      .q_vpn(q_vpn), .q_asid(lk_asid),
      .e_vpn(ent_vpn[g]), .e_asid(ent_asid[g]), .e_mask(ent_mask[g]),
      .e_global(ent_glob[g]), .hit(match_vec[g])
    );
  end

  tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req(match_vec), .found(any_match), .idx(sel)
  );

  // Masked page-number bits come from the virtual address (R3)
  assign mext  = {{PAD_W{1'b0}}, ent_mask[sel]};
  assign frame = (ent_pfn[sel] & ~mext) | (q_vpn & mext);

  always_comb begin
    if (!any_match)                           exc_d = EXC_REFILL;
    else if (!ent_valid[sel])                 exc_d = EXC_INVALID;
    else if (lk_store && !ent_dirty[sel])     exc_d = EXC_MODIFIED;
    else                                      exc_d = EXC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_exc   <= EXC_NONE;
      res_paddr <= '0;
      res_cattr <= '0;
    end else begin
      res_valid <= lk_valid;
      res_exc   <= exc_d;
      res_hit   <= (exc_d == EXC_NONE);
      if (exc_d == EXC_NONE) begin
        res_paddr <= {frame, lk_vaddr[PAGE_W-1:0]};
        res_cattr <= ent_cattr[sel];
      end else begin
        res_paddr <= '0;
        res_cattr <= '0;
      end
    end
  end

  a_r1_result_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  a_r7_exc_clean: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_exc != 2'd0) |->
      (!res_hit && res_paddr == '0 && res_cattr == '0));
  a_r6_load_not_modified: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_store) |=> res_exc != 2'd3);
  a_r11_no_locked_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_random) |-> wsel >= wired_cnt);
endmodule

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_store = 1'b0;
  logic        res_valid, res_hit;
  logic [1:0]  res_exc;
  logic [31:0] res_paddr;
  logic [2:0]  res_cattr;
  logic        wr_en = 1'b0, wr_random = 1'b0;
  logic [4:0]  wr_index = '0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0;
  logic [7:0]  wr_asid = '0, wr_mask = '0;
  logic        wr_global = 1'b0, wr_valid = 1'b0, wr_dirty = 1'b0;
  logic [2:0]  wr_cattr = '0;
  logic        wired_we = 1'b0;
  logic [4:0]  wired_val = '0;
  logic [4:0]  rand_idx;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0]  q_exc [$];
  logic [31:0] q_pa  [$];
  logic [2:0]  q_ca  [$];
  string       q_tag [$];

  int owner [32];

  always #10 clk = ~clk;

  tlb_xlate dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_store(lk_store), .res_valid(res_valid),
    .res_hit(res_hit), .res_exc(res_exc), .res_paddr(res_paddr),
    .res_cattr(res_cattr), .wr_en(wr_en), .wr_random(wr_random),
    .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_mask(wr_mask), .wr_global(wr_global), .wr_pfn(wr_pfn),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty), .wr_cattr(wr_cattr),
    .wired_we(wired_we), .wired_val(wired_val), .rand_idx(rand_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: issue one lookup and push the expected result
  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic st,
                        input logic [1:0] ex, input logic [31:0] pa,
                        input logic [2:0] ca, input string tag);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st;
    q_exc.push_back(ex); q_pa.push_back(pa); q_ca.push_back(ca); q_tag.push_back(tag);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic write_ent(input logic rnd, input logic [4:0] idx, input logic [19:0] vpn,
                           input logic [7:0] asid, input logic [7:0] mask, input logic g,
                           input logic [19:0] pfn, input logic v, input logic d,
                           input logic [2:0] ca);
    wr_en = 1'b1; wr_random = rnd; wr_index = idx; wr_vpn = vpn; wr_asid = asid;
    wr_mask = mask; wr_global = g; wr_pfn = pfn; wr_valid = v; wr_dirty = d; wr_cattr = ca;
    @(negedge clk);
    wr_en = 1'b0; wr_random = 1'b0;
  endtask

  task automatic set_wired(input logic [4:0] w);
    wired_we = 1'b1; wired_val = w;
    @(negedge clk);
    wired_we = 1'b0;
  endtask

  // Monitor: pop and compare each result as it appears
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (q_exc.size() == 0) begin
        check(1'b0, "R1 unexpected result", 1, 0);
      end else begin
        logic [1:0] ex; logic [31:0] pa; logic [2:0] ca; string tg;
        ex = q_exc.pop_front(); pa = q_pa.pop_front(); ca = q_ca.pop_front(); tg = q_tag.pop_front();
        checks++;
        if (res_exc !== ex || res_hit !== (ex == 2'd0) || res_paddr !== pa || res_cattr !== ca) begin
          fails++;
          $display("FAIL %s: exc %0d hit %0d pa %h ca %0d, expected exc %0d hit %0d pa %h ca %0d",
                   tg, res_exc, res_hit, res_paddr, res_cattr, ex, (ex == 2'd0), pa, ca);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check(res_valid == 1'b0, "R12 res_valid", res_valid, 0);
    check(rand_idx == 5'd31, "R12 rand_idx", rand_idx, 31);
    rst = 1'b0;
    lookup(32'h0, 8'h0, 1'b0, 2'd2, 32'h0, 3'd0, "R12 cleared entry is invalid");

    // R9/R10: full walk with locked count 0
    set_wired(5'd0);
    check(rand_idx == 5'd31, "R10 reload", rand_idx, 31);
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      check(rand_idx == ((k == 32) ? 5'd31 : 5'(31 - k)), "R9 walk", rand_idx,
            (k == 32) ? 31 : 31 - k);
    end
    // R9/R10: short cycle with locked count 29
    set_wired(5'd29);
    check(rand_idx == 5'd31, "R10 reload 29", rand_idx, 31);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(rand_idx == 5'(31 - ((k + 1) % 3)), "R9 wrap at locked count",
            rand_idx, 31 - ((k + 1) % 3));
    end

    // R8, R3: indexed writes and plain translation
    write_ent(1'b0, 5'd0, 20'h12345, 8'd5, 8'h00, 1'b0, 20'hABCDE, 1'b1, 1'b1, 3'd3);
    lookup(32'h12345678, 8'd5, 1'b0, 2'd0, 32'hABCDE678, 3'd3, "R8 R3 indexed translate");
    lookup(32'h12345678, 8'd6, 1'b0, 2'd1, 32'h0, 3'd0, "R2 R4 tag mismatch refill");
    // R2 global, R6 modified
    write_ent(1'b0, 5'd1, 20'h00400, 8'd9, 8'h00, 1'b1, 20'h00800, 1'b1, 1'b0, 3'd2);
    lookup(32'h00400123, 8'd77, 1'b0, 2'd0, 32'h00800123, 3'd2, "R2 global load");
    lookup(32'h00400123, 8'd77, 1'b1, 2'd3, 32'h0, 3'd0, "R6 store to clean page");
    // R3 masked page
    write_ent(1'b0, 5'd2, 20'h55500, 8'd1, 8'hFF, 1'b0, 20'h77700, 1'b1, 1'b1, 3'd1);
    lookup(32'h555AB010, 8'd1, 1'b1, 2'd0, 32'h777AB010, 3'd1, "R3 masked bits pass through");
    lookup(32'h556AB010, 8'd1, 1'b0, 2'd1, 32'h0, 3'd0, "R4 outside masked page");
    // R5 invalid
    write_ent(1'b0, 5'd3, 20'h66600, 8'd1, 8'h00, 1'b0, 20'h12000, 1'b0, 1'b1, 3'd5);
    lookup(32'h66600444, 8'd1, 1'b0, 2'd2, 32'h0, 3'd0, "R5 invalid entry R7");
    // R2 priority: lowest index wins
    write_ent(1'b0, 5'd4, 20'h12345, 8'd5, 8'h00, 1'b0, 20'h11111, 1'b1, 1'b1, 3'd4);
    lookup(32'h12345ABC, 8'd5, 1'b0, 2'd0, 32'hABCDEABC, 3'd3, "R2 lowest index wins");
    // R8 overwrite slot 0
    write_ent(1'b0, 5'd0, 20'h99999, 8'd5, 8'h00, 1'b0, 20'h22222, 1'b1, 1'b1, 3'd6);
    lookup(32'h12345ABC, 8'd5, 1'b0, 2'd0, 32'h11111ABC, 3'd4, "R8 overwrite exposes next");
    lookup(32'h99999001, 8'd5, 1'b0, 2'd0, 32'h22222001, 3'd6, "R8 new mapping");

    // R11: replacement writes with 8 locked entries
    set_wired(5'd8);
    for (int i = 0; i < 32; i++) owner[i] = -1;
    for (int k = 0; k < 24; k++) begin
      int t;
      t = int'(rand_idx);
      check(t >= 8, "R11 target above locked count", t, 8);
      owner[t] = k;
      write_ent(1'b1, 5'd0, 20'hC0000 + 20'(k), 8'd2, 8'h00, 1'b0, 20'hD0000 + 20'(k),
                1'b1, 1'b1, 3'd7);
    end
    for (int k = 0; k < 24; k++) begin
      bit present;
      present = 0;
      for (int i = 0; i < 32; i++) if (owner[i] == k) present = 1;
      if (present)
        lookup({20'hC0000 + 20'(k), 12'h034}, 8'd2, 1'b0, 2'd0,
               {20'hD0000 + 20'(k), 12'h034}, 3'd7, "R11 replacement mapping");
      else
        lookup({20'hC0000 + 20'(k), 12'h034}, 8'd2, 1'b0, 2'd1, 32'h0, 3'd0,
               "R11 overwritten mapping refills");
    end
    // R11: locked entries untouched
    lookup(32'h00400123, 8'd3, 1'b0, 2'd0, 32'h00800123, 3'd2, "R11 locked entry 1 kept");
    lookup(32'h555CD010, 8'd1, 1'b0, 2'd0, 32'h777CD010, 3'd1, "R11 locked entry 2 kept");
    lookup(32'h99999001, 8'd5, 1'b0, 2'd0, 32'h22222001, 3'd6, "R11 locked entry 0 kept");

    // R1: back-to-back lookups, then idle
    lk_valid = 1'b1; lk_vaddr = 32'h12345001; lk_asid = 8'd5; lk_store = 1'b0;
    q_exc.push_back(2'd0); q_pa.push_back(32'h11111001); q_ca.push_back(3'd4);
    q_tag.push_back("R1 back-to-back first");
    @(negedge clk);
    lookup(32'h77777001, 8'd5, 1'b0, 2'd1, 32'h0, 3'd0, "R1 back-to-back second");
    @(negedge clk);
    check(res_valid == 1'b0, "R1 idle gives no result", res_valid, 0);
    repeat (2) @(negedge clk);
    check(q_exc.size() == 0, "R1 all results returned", q_exc.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule